// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns characters held in an external transmit FIFO into asynchronous serial frames on a single TX line. Each frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The frame format comes from a control word that software may change at any time. The transmitter latches the format when a frame begins, so a change takes effect on the next frame.

Bit timing comes from an external baud generator as a one-cycle `bit_tick_i` pulse per bit period. The transmitter requests one FIFO entry per frame with a single-cycle pop strobe in the cycle of the tick that starts the frame. It reads the character from the FIFO head in that same cycle. A forced-break control drives the line low and abandons any frame in progress. An optional clear-to-send handshake holds back new frames, and is looked at only at frame boundaries.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd_o` is 1 and `busy_o` is 0. A frame begins with a single 0 start bit, followed by the data bits least significant first. Each bit holds for exactly one tick interval, and the line changes only in the cycle after a tick.
- R2: The data-bit count is set by control bits [8:6]. Values 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Values 4 to 7 give 8 bits.
- R3: When control bit 9 is 1, a parity bit follows the data bits. Control bit 10 = 1 makes the count of ones over data and parity even, and 0 makes it odd. When bit 9 is 0, no parity bit is sent.
- R4: Control bit 11 = 0 gives one stop bit and 1 gives two. Stop bits are 1.
- R5: Only bits [7:0] of the FIFO word form the character. Bits above 7 never reach the line.
- R6: While control bit 13 is 1, `txd_o` is 0 whatever the frame state.
- R7: While control bit 13 is 1, no FIFO entry is popped, any frame in progress is abandoned and `busy_o` is 0. After release, the engine starts from idle at the next tick.
- R8: When control bit 12 is 1, a new frame starts only if `cts_i` is 1 at the starting tick. A frame already started completes regardless of `cts_i`.
- R9: `fifo_pop_o` pulses for one cycle, only in a cycle with `bit_tick_i` high, only when the FIFO is not empty, and exactly once per frame. If data is waiting at the tick that ends the last stop bit, the next start bit follows with no idle bit.
- R10: The format fields (bits 11:6) are sampled when a frame starts. Changes during a frame apply only to later frames.
- R11: `busy_o` is 1 from the start bit through the last stop bit, and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | CTRL_W (14) | Control word: [8:6] length, 9 parity enable, 10 even parity, 11 two stops, 12 handshake enable, 13 force break |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| cts_i | input | 1 | Clear to send (1 = may start) |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| fifo_data_i | input | WORD_W (32) | FIFO head word |
| fifo_pop_o | output | 1 | Pop strobe for the FIFO head |
| txd_o | output | 1 | Serial output, idles high |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest situations to reach from the ports are a break raised partway through a frame and a clear-to-send drop in the middle of a frame. In both cases the outcome depends on which bit is on the line at that moment. The stimulus queues several characters and runs the tick pattern for a fixed number of cycles before toggling break or `cts_i`. The reference model's bit queue therefore decides what remains of the frame, and the bench checks that the FIFO depth is unchanged across the break. Format fields are also rewritten mid-frame to show that they are latched at the start.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int CNT_W    = 4;

    // control word bit positions (decoded by software and this block)
    localparam int LEN_LSB      = 6;
    localparam int LEN_W        = 3;
    localparam int PAR_EN_BIT   = 9;
    localparam int PAR_EVEN_BIT = 10;
    localparam int STOP2_BIT    = 11;
    localparam int HS_BIT       = 12;
    localparam int BRK_BIT      = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] nbits;
        logic             par_en;
        logic             par_even;
        logic             two_stop;
    } frame_fmt_t;

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-1:0] shreg;
        logic              par;
        frame_fmt_t        fmt;
        logic              txd;
        logic              busy;
    } eng_regs_t;

endpackage

// File: rtl/uart_tx_fmt_decode.sv
module uart_tx_fmt_decode
    import uart_tx_pkg::*;
#(
    parameter int CTRL_W = 14
) (
    input  logic [CTRL_W-1:0] ctrl,
    output frame_fmt_t        fmt,
    output logic              hs_en,
    output logic              brk
);

    logic [LEN_W-1:0] len_field;

    always_comb begin
        len_field = ctrl[LEN_LSB +: LEN_W];
        // codes with the top bit set saturate at the full character width
        if (len_field[LEN_W-1]) begin
            fmt.nbits = CNT_W'(CHAR_W);
        end else begin
            fmt.nbits = CNT_W'(MIN_BITS) + CNT_W'(len_field[LEN_W-2:0]);
        end
        fmt.par_en   = ctrl[PAR_EN_BIT];
        fmt.par_even = ctrl[PAR_EVEN_BIT];
        fmt.two_stop = ctrl[STOP2_BIT];
        hs_en        = ctrl[HS_BIT];
        brk          = ctrl[BRK_BIT];
    end

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              even,
    output logic              par_bit
);

    logic ones_odd;

    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (CNT_W'(i) < nbits) begin
                ones_odd = ones_odd ^ char_in[i];
            end
        end
        // even: parity bit evens out the count; odd: it makes the count odd
        par_bit = even ? ones_odd : ~ones_odd;
    end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              brk,
    input  logic              hs_en,
    input  logic              cts,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] char_in,
    input  frame_fmt_t        fmt_in,
    input  logic              par_in,
    output logic              pop,
    output logic              txd,
    output logic              busy
);

    eng_regs_t q, d;
    logic      start_ok;
    logic      frame_end;

    always_comb begin
        d         = q;
        pop       = 1'b0;
        frame_end = 1'b0;
        start_ok  = !fifo_empty && (!hs_en || cts);

        if (brk) begin
            d.state = ST_IDLE;
            d.txd   = 1'b1;
            d.busy  = 1'b0;
            d.cnt   = '0;
        end else if (tick) begin
            unique case (q.state)
                ST_IDLE: begin
                    frame_end = 1'b1;
                end
                ST_START: begin
                    d.state = ST_DATA;
                    d.txd   = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                    d.cnt   = '0;
                end
                ST_DATA: begin
                    if (q.cnt == q.fmt.nbits - CNT_W'(1)) begin
                        d.cnt = '0;
                        if (q.fmt.par_en) begin
                            d.state = ST_PARITY;
                            d.txd   = q.par;
                        end else begin
                            d.state = ST_STOP;
                            d.txd   = 1'b1;
                        end
                    end else begin
                        d.cnt   = q.cnt + CNT_W'(1);
                        d.txd   = q.shreg[0];
                        d.shreg = q.shreg >> 1;
                    end
                end
                ST_PARITY: begin
                    d.state = ST_STOP;
                    d.txd   = 1'b1;
                    d.cnt   = '0;
                end
                ST_STOP: begin
                    if (q.fmt.two_stop && q.cnt == '0) begin
                        d.cnt = CNT_W'(1);
                        d.txd = 1'b1;
                    end else begin
                        frame_end = 1'b1;
                    end
                end
                default: begin
                    d.state = ST_IDLE;
                end
            endcase

            if (frame_end) begin
                if (start_ok) begin
                    pop     = 1'b1;
                    d.state = ST_START;
                    d.txd   = 1'b0;
                    d.busy  = 1'b1;
                    d.shreg = char_in;
                    d.fmt   = fmt_in;
                    d.par   = par_in;
                    d.cnt   = '0;
                end else begin
                    d.state = ST_IDLE;
                    d.txd   = 1'b1;
                    d.busy  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.txd   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd  = q.txd;
    assign busy = q.busy;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CTRL_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              bit_tick_i,
    input  logic              cts_i,
    input  logic              fifo_empty_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    output logic              txd_o,
    output logic              busy_o
);

    frame_fmt_t        fmt;
    logic              hs_en;
    logic              force_brk;
    logic              par_bit;
    logic              line_q;
    logic [CHAR_W-1:0] char_w;
    logic              unused_bits;

    assign char_w      = fifo_data_i[CHAR_W-1:0];
    assign unused_bits = ^{fifo_data_i[WORD_W-1:CHAR_W], ctrl_i[LEN_LSB-1:0]};

    uart_tx_fmt_decode #(
        .CTRL_W (CTRL_W)
    ) u_decode (
        .ctrl  (ctrl_i),
        .fmt   (fmt),
        .hs_en (hs_en),
        .brk   (force_brk)
    );

    uart_tx_parity u_parity (
        .char_in (char_w),
        .nbits   (fmt.nbits),
        .even    (fmt.par_even),
        .par_bit (par_bit)
    );

    uart_tx_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick_i),
        .brk        (force_brk),
        .hs_en      (hs_en),
        .cts        (cts_i),
        .fifo_empty (fifo_empty_i),
        .char_in    (char_w),
        .fmt_in     (fmt),
        .par_in     (par_bit),
        .pop        (fifo_pop_o),
        .txd        (line_q),
        .busy       (busy_o)
    );

    // break overrides the line immediately, independent of the engine
    assign txd_o = force_brk ? 1'b0 : line_q;

endmodule

// File: rtl/uart_frame_tx_checker.sv
module uart_frame_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic brk,
    input logic hs_en,
    input logic cts,
    input logic fifo_empty,
    input logic tick,
    input logic pop,
    input logic txd,
    input logic busy
);

    AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd); // R6

    AST_BREAK_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !pop); // R7

    AST_BREAK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !busy); // R7

    AST_HANDSHAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !cts) |-> !pop); // R8

    AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (tick && !fifo_empty)); // R9

    AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (busy && (txd == 1'b0))); // R1

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |-> txd); // R11

endmodule

bind uart_frame_tx uart_frame_tx_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk        (force_brk),
    .hs_en      (hs_en),
    .cts        (cts_i),
    .fifo_empty (fifo_empty_i),
    .tick       (bit_tick_i),
    .pop        (fifo_pop_o),
    .txd        (txd_o),
    .busy       (busy_o)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ctrl = '0;
    logic        tick = 1'b0;
    logic        cts = 1'b1;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_data = '0;
    logic        fifo_pop;
    logic        txd;
    logic        busy;

    always #4 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_i       (ctrl),
        .bit_tick_i   (tick),
        .cts_i        (cts),
        .fifo_empty_i (fifo_empty),
        .fifo_data_i  (fifo_data),
        .fifo_pop_o   (fifo_pop),
        .txd_o        (txd),
        .busy_o       (busy)
    );

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    string       cur_req = "R1";
    logic [13:0] ctrl_nx = '0;
    logic        cts_nx = 1'b1;

    logic [31:0] fifo_q[$];
    bit          bits_m[$];
    bit          line_m = 1'b1;
    bit          busy_m = 1'b0;

    function automatic logic [13:0] mk_ctrl(int len, bit pen, bit peven, bit two, bit hs, bit brk);
        logic [13:0] c;
        c = '0;
        c[8:6] = 3'(len);
        c[9] = pen;
        c[10] = peven;
        c[11] = two;
        c[12] = hs;
        c[13] = brk;
        return c;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // builds the expected bit sequence of a frame from the requirements
    task automatic load_frame(logic [31:0] w, logic [13:0] c);
        int n;
        bit p;
        n = (c[8] == 1'b1) ? 8 : 5 + int'(c[7:6]);
        p = 1'b0;
        bits_m.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            bits_m.push_back(w[i]);
            p = p ^ w[i];
        end
        if (c[9]) bits_m.push_back(c[10] ? p : ~p);
        bits_m.push_back(1'b1);
        if (c[11]) bits_m.push_back(1'b1);
    endtask

    task automatic step(bit tk);
        bit start_ok;
        bit pop_exp;
        @(negedge clk);
        chk(cur_req, "txd", int'(txd), ctrl[13] ? 0 : int'(line_m));
        chk(cur_req, "busy", int'(busy), int'(busy_m));
        ctrl = ctrl_nx;
        cts = cts_nx;
        tick = tk;
        fifo_empty = (fifo_q.size() == 0);
        fifo_data = (fifo_q.size() == 0) ? 32'h0 : fifo_q[0];
        #1;
        start_ok = (fifo_q.size() != 0) && (!ctrl[12] || cts);
        pop_exp = tick && !ctrl[13] && (bits_m.size() == 0) && start_ok;
        chk(cur_req, "pop", int'(fifo_pop), int'(pop_exp));
        @(posedge clk);
        if (ctrl[13]) begin
            bits_m.delete();
            line_m = 1'b1;
            busy_m = 1'b0;
        end else if (tick) begin
            if (bits_m.size() != 0) begin
                line_m = bits_m.pop_front();
            end else if (pop_exp) begin
                load_frame(fifo_q[0], ctrl);
                void'(fifo_q.pop_front());
                line_m = bits_m.pop_front();
                busy_m = 1'b1;
            end else begin
                line_m = 1'b1;
                busy_m = 1'b0;
            end
        end
    endtask

    task automatic run(int n, int period);
        for (int i = 0; i < n; i++) begin
            step((i % period) == (period - 1));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int depth;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset txd", int'(txd), 1);
        chk("R11", "reset busy", int'(busy), 0);
        rst_n = 1'b1;

        // R1 R9 R11: 8N1, back-to-back characters
        cur_req = "R1 R9 R11";
        ctrl_nx = mk_ctrl(3, 0, 0, 0, 0, 0);
        fifo_q.push_back(32'hA5);
        fifo_q.push_back(32'h3C);
        fifo_q.push_back(32'hFF);
        run(140, 4);
        chk("R9", "fifo drained", fifo_q.size(), 0);

        // R2 R3 R4: 5 bits, even parity, two stops
        cur_req = "R2 R3 R4";
        ctrl_nx = mk_ctrl(0, 1, 1, 1, 0, 0);
        fifo_q.push_back(32'h13);
        fifo_q.push_back(32'hFE);
        run(100, 3);

        // R3: 7 bits odd parity, tick every cycle
        cur_req = "R3";
        ctrl_nx = mk_ctrl(2, 1, 0, 0, 0, 0);
        fifo_q.push_back(32'h55);
        fifo_q.push_back(32'h00);
        fifo_q.push_back(32'h7F);
        run(50, 1);

        // R2 R5: saturating length code, upper word bits set
        cur_req = "R2 R5";
        ctrl_nx = mk_ctrl(6, 0, 0, 0, 0, 0);
        fifo_q.push_back(32'hDEADBE81);
        fifo_q.push_back(32'hFFFFFF00);
        run(60, 2);
        ctrl_nx = mk_ctrl(1, 1, 1, 0, 0, 0);
        fifo_q.push_back(32'hABCDEF2A);
        run(40, 2);

        // R10: format rewritten mid-frame
        cur_req = "R10";
        ctrl_nx = mk_ctrl(0, 0, 0, 0, 0, 0);
        fifo_q.push_back(32'h15);
        fifo_q.push_back(32'hC3);
        run(10, 3);
        ctrl_nx = mk_ctrl(3, 1, 0, 1, 0, 0);
        run(80, 3);

        // R8: handshake holds new frames, not the current one
        cur_req = "R8";
        ctrl_nx = mk_ctrl(3, 0, 0, 0, 1, 0);
        cts_nx = 1'b0;
        fifo_q.push_back(32'h96);
        fifo_q.push_back(32'h69);
        run(40, 4);
        chk("R8", "held depth", fifo_q.size(), 2);
        cts_nx = 1'b1;
        run(14, 4);
        cts_nx = 1'b0;
        run(60, 4);
        chk("R8", "second held", fifo_q.size(), 1);
        chk("R8", "idle after frame", int'(busy), 0);
        cts_nx = 1'b1;
        run(50, 4);

        // R6 R7: break mid-frame, then release
        cur_req = "R6 R7";
        ctrl_nx = mk_ctrl(3, 1, 1, 0, 0, 0);
        fifo_q.push_back(32'h5A);
        fifo_q.push_back(32'h81);
        fifo_q.push_back(32'h44);
        run(18, 3);
        ctrl_nx = mk_ctrl(3, 1, 1, 0, 0, 1);
        depth = fifo_q.size();
        run(30, 3);
        chk("R7", "no pop in break", fifo_q.size(), depth);
        chk("R6", "line low in break", int'(txd), 0);
        chk("R7", "busy in break", int'(busy), 0);
        ctrl_nx = mk_ctrl(3, 1, 1, 0, 0, 0);
        run(120, 3);
        chk("R7", "drained after release", fifo_q.size(), 0);

        // R6: break while idle with data waiting
        cur_req = "R6 R7";
        ctrl_nx = mk_ctrl(2, 0, 0, 0, 0, 1);
        fifo_q.push_back(32'h33);
        run(20, 2);
        chk("R7", "idle break depth", fifo_q.size(), 1);
        ctrl_nx = mk_ctrl(2, 0, 0, 0, 0, 0);
        run(40, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule